// File: doc/BRIEF.md
# Hotswap Inrush and Fault Sequencer

This block holds the digital control for an input pass switch that sits between a powered line and a downstream converter. It samples digitised readings of the supply voltage, the return-node voltage and the switch current. From these it selects one of three switch modes: off, a low inrush current limit, or the higher operating current limit. An analog loop enforces the chosen limit; this block only picks it. The block also drives an enable for an auxiliary parallel gate, an active-low converter-disable signal and an active-low indicator that reports a latched high-power source classification.

After power-up the switch starts in inrush mode. It moves to the operating limit once the sensed current falls below a set percentage of the inrush limit. The auxiliary gate enable rises only at that point. The converter is released only once the auxiliary gate reports that it is fully enhanced. Two fault timers run in parallel, and each counts clock cycles scaled to microseconds. One drops the auxiliary gate enable if the current sits at the operating limit for too long. The other returns the switch to inrush mode if the return node stays high for too long. Over-temperature, a low enable or an under-voltage condition turns the switch off.

Top module: `hs_sequencer`

## Requirements
- R1: The switch leaves the off mode only after the supply code has exceeded UV_RISE (default 381, 0.1 V per LSB). It then stays on until the supply code drops below UV_FALL (default 320). The hysteresis flag takes one cycle and the mode change one more.
- R2: While reset is asserted, sw_mode is 0 (off), aux_gate_en is 0, conv_off_n is 0 and t2_ind_n is 1.
- R3: In inrush mode the switch moves to operating mode on the next clock when isns_code is below INRUSH_LIM*TERM_PCT/100 (default 126, 1 mA per LSB). Otherwise it stays in inrush.
- R4: aux_gate_en is high only in operating mode. It rises together with the move from inrush into operating mode.
- R5: conv_off_n is low (converter held off) in the off and inrush modes. In operating mode it goes high once aux_ready has been seen high, and it stays high for the rest of that operating period.
- R6: If at_limit is held high in operating mode for GATE_US*CYC_PER_US consecutive cycles (default 730), aux_gate_en falls at the last of those edges. It stays low until a later inrush period completes.
- R7: If vret_code stays above FOLD_CODE (default 120) in operating mode for FOLD_US*CYC_PER_US consecutive cycles (default 1600), the mode returns to inrush at the last of those edges.
- R8: Each fault counter clears at once when its condition is absent for a cycle. Interrupted conditions therefore never trip either timer.
- R9: over_temp high or sw_enable low forces the off mode, with aux_gate_en low, on the next clock edge.
- R10: When the shutdown cause clears, the switch restarts in inrush mode. aux_gate_en rises again only when that inrush ends.
- R11: t2_ind_n is low exactly when t2_latched is high, the next mode is not inrush and over_temp is low. It is registered.
- R12: sw_mode encodes off as 0, inrush as 1 and operating as 2. The off mode is never followed directly by operating mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vin_code | input | V_W | Supply voltage code |
| vret_code | input | V_W | Return-node voltage code |
| isns_code | input | I_W | Switch current code |
| at_limit | input | 1 | Analog loop reports current held at the operating limit |
| aux_ready | input | 1 | Auxiliary gate voltage above its enhanced level |
| over_temp | input | 1 | Thermal shutdown request |
| sw_enable | input | 1 | Low forces the switch off |
| t2_latched | input | 1 | High-power source classification latched |
| sw_mode | output | 2 | Registered switch mode (0 off, 1 inrush, 2 operating) |
| aux_gate_en | output | 1 | Auxiliary gate enable |
| conv_off_n | output | 1 | Converter disable, active low |
| t2_ind_n | output | 1 | High-power source indicator, active low |

## Verification
The embedded properties watch, on every cycle, that the gate enable and the converter release occur only in operating mode. They also check that the gate enable rises only out of inrush, that a shutdown input reaches the off mode one edge later, that off never jumps straight to operating mode, that the indicator stays inactive during inrush, and that each fault counter resets when its condition drops and stays within its bound. Some behaviour only the bench scenarios can show. This covers the exact expiry edge of the 730-cycle and 1600-cycle timers, the way interrupted faults fail to trip them, the supply hysteresis band, and the full restart sequence after a thermal event or a disable.

// File: rtl/hs_pkg.sv
package hs_pkg;

    typedef enum logic [1:0] {
        HS_OFF    = 2'd0,
        HS_INRUSH = 2'd1,
        HS_OPER   = 2'd2
    } hs_mode_e;

    typedef struct packed {
        hs_mode_e mode;
        logic     gate;
        logic     conv_rel;
        logic     t2_act;
    } hs_state_t;

endpackage

// File: rtl/hs_uvlo.sv
module hs_uvlo #(
    parameter int W    = 10,
    parameter int RISE = 381,
    parameter int FALL = 320
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] code,
    output logic         ok
);
    localparam logic [W-1:0] RISE_C = W'(RISE);
    localparam logic [W-1:0] FALL_C = W'(FALL);

    logic ok_d, ok_q;

    always_comb begin
        if (ok_q) ok_d = (code >= FALL_C);
        else      ok_d = (code >  RISE_C);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ok_q <= 1'b0;
        else        ok_q <= ok_d;
    end

    assign ok = ok_q;

    // Inside the band the flag keeps its value
    p_band_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (code >= FALL_C && code <= RISE_C) |=> (ok_q == $past(ok_q)));

endmodule

// File: rtl/hs_deglitch.sv
module hs_deglitch #(
    parameter int LIMIT = 730
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cond,
    output logic expire
);
    localparam int             CW   = $clog2(LIMIT + 1);
    localparam logic [CW-1:0]  LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        expire = cond && (cnt_q == LAST);
        if (!cond)       cnt_d = '0;
        else if (expire) cnt_d = '0;
        else             cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    p_clear_on_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cond |=> (cnt_q == '0));

    p_count_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

endmodule

// File: rtl/hs_sequencer.sv
module hs_sequencer #(
    parameter int V_W        = 10,
    parameter int I_W        = 10,
    parameter int CYC_PER_US = 2,
    parameter int UV_RISE    = 381,
    parameter int UV_FALL    = 320,
    parameter int INRUSH_LIM = 140,
    parameter int TERM_PCT   = 90,
    parameter int FOLD_CODE  = 120,
    parameter int GATE_US    = 365,
    parameter int FOLD_US    = 800
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [V_W-1:0] vin_code,
    input  logic [V_W-1:0] vret_code,
    input  logic [I_W-1:0] isns_code,
    input  logic           at_limit,
    input  logic           aux_ready,
    input  logic           over_temp,
    input  logic           sw_enable,
    input  logic           t2_latched,
    output logic [1:0]     sw_mode,
    output logic           aux_gate_en,
    output logic           conv_off_n,
    output logic           t2_ind_n
);
    import hs_pkg::*;

    localparam int             GATE_CYC = GATE_US * CYC_PER_US;
    localparam int             FOLD_CYC = FOLD_US * CYC_PER_US;
    localparam logic [I_W-1:0] TERM_C   = I_W'((INRUSH_LIM * TERM_PCT) / 100);
    localparam logic [V_W-1:0] FOLD_C   = V_W'(FOLD_CODE);

    hs_state_t st_d, st_q;
    logic      uv_ok;
    logic      kill;
    logic      fold_cond, fold_exp;
    logic      gate_cond, gate_exp;

    hs_uvlo #(.W(V_W), .RISE(UV_RISE), .FALL(UV_FALL)) u_uvlo (
        .clk  (clk),
        .rst_n(rst_n),
        .code (vin_code),
        .ok   (uv_ok)
    );

    assign fold_cond = (st_q.mode == HS_OPER) && (vret_code > FOLD_C);
    assign gate_cond = (st_q.mode == HS_OPER) && st_q.gate && at_limit;

    hs_deglitch #(.LIMIT(FOLD_CYC)) u_fold_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .cond  (fold_cond),
        .expire(fold_exp)
    );

    hs_deglitch #(.LIMIT(GATE_CYC)) u_gate_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .cond  (gate_cond),
        .expire(gate_exp)
    );

    always_comb begin
        kill = over_temp || !sw_enable || !uv_ok;
        st_d = st_q;

        unique case (st_q.mode)
            HS_OFF: begin
                if (!kill) st_d.mode = HS_INRUSH;
            end
            HS_INRUSH: begin
                if (kill)                    st_d.mode = HS_OFF;
                else if (isns_code < TERM_C) st_d.mode = HS_OPER;
            end
            HS_OPER: begin
                if (kill)          st_d.mode = HS_OFF;
                else if (fold_exp) st_d.mode = HS_INRUSH;
            end
            default: st_d.mode = HS_OFF;
        endcase

        st_d.gate     = (st_d.mode == HS_OPER) &&
                        ((st_q.mode == HS_INRUSH) || (st_q.gate && !gate_exp));
        st_d.conv_rel = (st_d.mode == HS_OPER) && (st_q.conv_rel || aux_ready);
        st_d.t2_act   = t2_latched && (st_d.mode != HS_INRUSH) && !over_temp;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mode     <= HS_OFF;
            st_q.gate     <= 1'b0;
            st_q.conv_rel <= 1'b0;
            st_q.t2_act   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sw_mode     = st_q.mode;
    assign aux_gate_en = st_q.gate;
    assign conv_off_n  = st_q.conv_rel;
    assign t2_ind_n    = !st_q.t2_act;

    p_gate_only_oper_r4: assert property (@(posedge clk) disable iff (!rst_n)
        aux_gate_en |-> (sw_mode == HS_OPER));

    p_conv_only_oper_r5: assert property (@(posedge clk) disable iff (!rst_n)
        conv_off_n |-> (sw_mode == HS_OPER));

    p_shutdown_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (over_temp || !sw_enable) |=> (sw_mode == HS_OFF && !aux_gate_en));

    p_gate_after_inrush_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(aux_gate_en) |-> ($past(sw_mode) == HS_INRUSH));

    p_no_skip_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_mode == HS_OFF) |=> (sw_mode != HS_OPER));

    p_t2_quiet_inrush_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_mode == HS_INRUSH) |-> t2_ind_n);

endmodule

// File: tb/sim_hs_sequencer.sv
module sim_hs_sequencer;

    localparam int CLK_P    = 10;
    localparam int GATE_CYC = 365 * 2;
    localparam int FOLD_CYC = 800 * 2;
    localparam int SETTLE   = 4;

    typedef struct packed {
        logic [9:0] vin;
        logic [9:0] isns;
        logic       ot;
        logic       en;
        logic       aux;
        logic       t2l;
        logic [1:0] mode;
        logic       gate;
        logic       conv;
        logic       t2n;
        logic [3:0] req;
    } vec_t;

    // Mode codes per R12: 0 off, 1 inrush, 2 operating
    localparam vec_t TBL [17] = '{
        '{10'd300, 10'd140, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 4'd1},  // R1 below band
        '{10'd350, 10'd140, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 4'd1},  // R1 inside band
        '{10'd390, 10'd140, 1'b0, 1'b1, 1'b0, 1'b0, 2'd1, 1'b0, 1'b0, 1'b1, 4'd1},  // R1 rise
        '{10'd390, 10'd130, 1'b0, 1'b1, 1'b0, 1'b0, 2'd1, 1'b0, 1'b0, 1'b1, 4'd3},  // R3 above 126
        '{10'd390, 10'd100, 1'b0, 1'b1, 1'b0, 1'b0, 2'd2, 1'b1, 1'b0, 1'b1, 4'd5},  // R5 no ready
        '{10'd390, 10'd100, 1'b0, 1'b1, 1'b1, 1'b0, 2'd2, 1'b1, 1'b1, 1'b1, 4'd5},  // R5 released
        '{10'd390, 10'd100, 1'b0, 1'b1, 1'b1, 1'b1, 2'd2, 1'b1, 1'b1, 1'b0, 4'd11}, // R11
        '{10'd330, 10'd100, 1'b0, 1'b1, 1'b1, 1'b1, 2'd2, 1'b1, 1'b1, 1'b0, 4'd1},  // R1 hysteresis
        '{10'd310, 10'd140, 1'b0, 1'b1, 1'b1, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 4'd1},  // R1 fall
        '{10'd390, 10'd140, 1'b0, 1'b1, 1'b1, 1'b1, 2'd1, 1'b0, 1'b0, 1'b1, 4'd11}, // R11 inrush
        '{10'd390, 10'd50,  1'b0, 1'b1, 1'b1, 1'b1, 2'd2, 1'b1, 1'b1, 1'b0, 4'd3},  // R3
        '{10'd390, 10'd140, 1'b1, 1'b1, 1'b1, 1'b1, 2'd0, 1'b0, 1'b0, 1'b1, 4'd9},  // R9 thermal
        '{10'd390, 10'd140, 1'b0, 1'b1, 1'b1, 1'b1, 2'd1, 1'b0, 1'b0, 1'b1, 4'd10}, // R10 restart
        '{10'd390, 10'd50,  1'b0, 1'b1, 1'b1, 1'b1, 2'd2, 1'b1, 1'b1, 1'b0, 4'd10}, // R10 gate back
        '{10'd390, 10'd140, 1'b0, 1'b0, 1'b1, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 4'd9},  // R9 disable
        '{10'd390, 10'd140, 1'b0, 1'b1, 1'b1, 1'b1, 2'd1, 1'b0, 1'b0, 1'b1, 4'd9},  // R9 re-enable
        '{10'd390, 10'd50,  1'b0, 1'b1, 1'b1, 1'b1, 2'd2, 1'b1, 1'b1, 1'b0, 4'd4}   // R4
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] vin_code = '0;
    logic [9:0] vret_code = '0;
    logic [9:0] isns_code = '0;
    logic       at_limit = 1'b0;
    logic       aux_ready = 1'b0;
    logic       over_temp = 1'b0;
    logic       sw_enable = 1'b1;
    logic       t2_latched = 1'b0;
    logic [1:0] sw_mode;
    logic       aux_gate_en, conv_off_n, t2_ind_n;

    int n_chk = 0;
    int n_bad = 0;
    logic done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    hs_sequencer u0 (
        .clk(clk), .rst_n(rst_n), .vin_code(vin_code), .vret_code(vret_code),
        .isns_code(isns_code), .at_limit(at_limit), .aux_ready(aux_ready),
        .over_temp(over_temp), .sw_enable(sw_enable), .t2_latched(t2_latched),
        .sw_mode(sw_mode), .aux_gate_en(aux_gate_en), .conv_off_n(conv_off_n),
        .t2_ind_n(t2_ind_n)
    );

    task automatic chk(input string what, input int req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL R%0d %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk_all(input int req, input int m, input int g, input int c, input int t);
        chk("mode", req, int'(sw_mode), m);
        chk("gate", req, int'(aux_gate_en), g);
        chk("conv", req, int'(conv_off_n), c);
        chk("t2n",  req, int'(t2_ind_n), t);
    endtask

    initial begin
        int guard = 0;
        while (!done && guard < 150000) begin
            @(posedge clk);
            guard++;
        end
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        // R2: reset state
        step(2);
        chk_all(2, 0, 0, 0, 1);
        rst_n = 1'b1;
        step(1);

        for (int i = 0; i < 17; i++) begin
            vin_code   = TBL[i].vin;
            isns_code  = TBL[i].isns;
            over_temp  = TBL[i].ot;
            sw_enable  = TBL[i].en;
            aux_ready  = TBL[i].aux;
            t2_latched = TBL[i].t2l;
            step(SETTLE);
            chk_all(int'(TBL[i].req), int'(TBL[i].mode), int'(TBL[i].gate),
                    int'(TBL[i].conv), int'(TBL[i].t2n));
        end

        // R8: interrupted at-limit never trips the gate timer
        at_limit = 1'b1;
        step(GATE_CYC - 1);
        at_limit = 1'b0;
        step(1);
        at_limit = 1'b1;
        step(GATE_CYC - 1);
        chk("gate after broken limit", 8, int'(aux_gate_en), 1);

        // R6: sustained at-limit drops the gate exactly at expiry
        at_limit = 1'b0;
        step(1);
        at_limit = 1'b1;
        step(GATE_CYC - 1);
        chk("gate one cycle early", 6, int'(aux_gate_en), 1);
        step(1);
        chk("gate at expiry", 6, int'(aux_gate_en), 0);
        chk("mode kept", 6, int'(sw_mode), 2);
        chk("conv kept", 6, int'(conv_off_n), 1);
        at_limit = 1'b0;
        step(10);
        chk("gate stays low", 6, int'(aux_gate_en), 0);

        // R8: interrupted high return voltage never folds back
        isns_code = 10'd140;
        vret_code = 10'd200;
        step(FOLD_CYC - 1);
        vret_code = 10'd0;
        step(1);
        vret_code = 10'd200;
        step(FOLD_CYC - 1);
        chk("mode after broken fold", 8, int'(sw_mode), 2);

        // R7: one more cycle completes the window
        step(1);
        chk("fold to inrush", 7, int'(sw_mode), 1);
        chk("conv held in inrush", 7, int'(conv_off_n), 0);
        chk("gate low in inrush", 7, int'(aux_gate_en), 0);

        // R6/R10: gate returns after inrush completes
        vret_code = 10'd0;
        isns_code = 10'd50;
        step(1);
        chk("gate rises again", 6, int'(aux_gate_en), 1);
        chk("mode operating", 10, int'(sw_mode), 2);

        // R2: reset in the middle of operation
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk_all(2, 0, 0, 0, 1);
        step(1);
        rst_n = 1'b1;

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule